// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel PCM stream made of a bit clock, a word clock that marks left and right half-frames, and one serial data line. It turns each frame into a left and a right parallel sample of 24 bits. A single valid strobe announces that both samples of a frame are ready. All three serial lines are brought into the system clock domain and sampled there. The bit clock must stay high and low for at least two system clock periods each.

A 3-bit select input chooses the framing at run time. The choices are MSB-first left-justified, I2S with its one-bit delay, and right-justified words of 16, 18, 20 or 24 bits. The two remaining codes are refused. A change of the select takes effect only at a frame boundary, and the frame in progress at that moment is dropped. A power-down input stops reception and discards any partial frame. It leaves the committed format as it was, so reception resumes in the same framing once it is cleared.

Top module: `pcm_rx`

## Requirements
- R1: After reset, valid_o is low, left_o and right_o are zero, and the committed format is code 000 (left-justified).
- R2: Code 000 selects left-justified framing: word clock high marks the left half, the MSB is on the first rising bit-clock edge after a word-clock transition, and the first 24 bits of each half form the sample.
- R3: Code 001 selects I2S framing: word clock low marks the left half, the MSB is on the second rising bit-clock edge after a transition, and 24 bits follow it.
- R4: Codes 010, 011, 100 and 101 select right-justified framing of 16, 24, 20 and 18 bits: word clock high marks the left half, and the sample is the last N bits before the word-clock transition.
- R5: A sample narrower than 24 bits is sign-extended: bits N..23 repeat bit N-1.
- R6: valid_o is a one-cycle pulse, raised once per frame after the right half ends, and left_o and right_o change together only with it.
- R7: Codes 110 and 111 never raise valid_o, and left_o and right_o keep their last values while either code is committed.
- R8: While pwrdn_i is high, valid_o stays low and partial frames are dropped. The committed format is neither reset nor changed.
- R9: A new select value is committed only at the end of a right half-frame. The frame during which the select changed produces no valid_o.
- R10: After reset or the release of pwrdn_i, the half-frame already in progress is ignored. The first pulse belongs to the first left and right pair that was received in full.
- R11: The serial inputs pass through a two-stage synchronizer. valid_o rises on the third system clock edge after the rising bit-clock edge that ends the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, data taken on its rising edge |
| lrck_i | input | 1 | Word clock marking left and right half-frames |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 3 | Framing select code |
| pwrdn_i | input | 1 | Power-down, high holds reception idle |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A wrong bit counter or alignment offset would first show as samples shifted by one bit or cut short. The error appears in the very first valid pair after the bad edge, so each framing is driven with patterns that have a distinct MSB and LSB. A stale left/right or armed flag would show up as a missing or extra pulse. So the bench counts pulses across power-down release, select changes and reserved codes, and does not only compare values. A wrong committed format would make the first frame after power-down be dropped or be misread. The pulse latency is measured against the bit-clock edge that ends the frame.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam logic [2:0] FMT_LJ   = 3'b000;
  localparam logic [2:0] FMT_I2S  = 3'b001;
  localparam logic [2:0] FMT_RJ16 = 3'b010;
  localparam logic [2:0] FMT_RJ24 = 3'b011;
  localparam logic [2:0] FMT_RJ20 = 3'b100;
  localparam logic [2:0] FMT_RJ18 = 3'b101;

  function automatic logic fmt_reserved(input logic [2:0] f);
    return (f == 3'b110) || (f == 3'b111);
  endfunction

  // Word length kept from the end of a right-justified half-frame, 0 otherwise.
  function automatic int unsigned rj_width(input logic [2:0] f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ24: return 24;
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_n [STAGES];

  always_comb begin
    stage_n[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_n[s] = stage_q[s-1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_n[g];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_MAX = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                stb_i,
  input  logic                start_i,
  input  logic                bit_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] sample_o
);

  localparam int HEAD_W = SAMPLE_W + 1;
  localparam int CNT_W  = $clog2(SLOT_MAX + 1);

  logic [HEAD_W-1:0]   head_q, head_n;
  logic [SAMPLE_W-1:0] tail_q, tail_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    cnt_n  = cnt_q;
    if (clr_i) begin
      head_n = '0;
      tail_n = '0;
      cnt_n  = '0;
    end else if (stb_i) begin
      tail_n = {tail_q[SAMPLE_W-2:0], bit_i};
      if (start_i) begin
        head_n    = '0;
        head_n[0] = bit_i;
        cnt_n     = CNT_W'(1);
      end else begin
        for (int i = 0; i < HEAD_W; i++)
          if (cnt_q == CNT_W'(i)) head_n[i] = bit_i;
        if (cnt_q != CNT_W'(SLOT_MAX)) cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  // Extraction of the completed half-frame, read before the new half overwrites it.
  always_comb begin
    int unsigned n;
    logic        sgn;
    n        = rj_width(fmt_i);
    sgn      = 1'b0;
    sample_o = '0;
    if (fmt_i == FMT_LJ) begin
      for (int i = 0; i < SAMPLE_W; i++) sample_o[SAMPLE_W-1-i] = head_q[i];
    end else if (fmt_i == FMT_I2S) begin
      for (int i = 0; i < SAMPLE_W; i++) sample_o[SAMPLE_W-1-i] = head_q[i+1];
    end else if (n != 0) begin
      for (int j = 0; j < SAMPLE_W; j++) if (j == int'(n) - 1) sgn = tail_q[j];
      for (int i = 0; i < SAMPLE_W; i++) sample_o[i] = (i < int'(n)) ? tail_q[i] : sgn;
    end
  end

  // R2
  head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && start_i && !clr_i) |=> (head_q[0] == $past(bit_i)));

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_MAX    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  input  logic                pwrdn_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [2:0] sync_w;
  logic       bclk_s, lrck_s, sdata_s;

  pcm_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   ({bclk_i, lrck_i, sdata_i}),
    .q_o   (sync_w)
  );
  assign {bclk_s, lrck_s, sdata_s} = sync_w;

  logic                bclk_d_q;
  logic                lr_prev_q, lr_prev_n;
  logic                armed_q, armed_n;
  logic                left_ok_q, left_ok_n;
  logic                dirty_q, dirty_n;
  logic [2:0]          fmt_q, fmt_n;
  logic [SAMPLE_W-1:0] hold_l_q, hold_l_n;
  logic [SAMPLE_W-1:0] left_n, right_n;
  logic                valid_n;
  logic                bit_stb, half_start, half_left, drop;
  logic [SAMPLE_W-1:0] sample_w;

  assign bit_stb    = bclk_s & ~bclk_d_q;
  assign half_start = bit_stb & (lrck_s != lr_prev_q);
  assign half_left  = (fmt_q == FMT_I2S) ? ~lr_prev_q : lr_prev_q;

  pcm_rx_slot #(.SAMPLE_W(SAMPLE_W), .SLOT_MAX(SLOT_MAX)) u_slot (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr_i    (pwrdn_i),
    .stb_i    (bit_stb),
    .start_i  (half_start),
    .bit_i    (sdata_s),
    .fmt_i    (fmt_q),
    .sample_o (sample_w)
  );

  always_comb begin
    lr_prev_n = bit_stb ? lrck_s : lr_prev_q;
    armed_n   = armed_q;
    left_ok_n = left_ok_q;
    dirty_n   = dirty_q | (fmt_i != fmt_q);
    fmt_n     = fmt_q;
    hold_l_n  = hold_l_q;
    left_n    = left_o;
    right_n   = right_o;
    valid_n   = 1'b0;
    drop      = dirty_n | fmt_reserved(fmt_q);
    if (pwrdn_i) begin
      armed_n   = 1'b0;
      left_ok_n = 1'b0;
      dirty_n   = 1'b0;
    end else if (half_start) begin
      armed_n = 1'b1;
      if (armed_q) begin
        if (half_left) begin
          hold_l_n  = sample_w;
          left_ok_n = 1'b1;
        end else begin
          if (left_ok_q && !drop) begin
            left_n  = hold_l_q;
            right_n = sample_w;
            valid_n = 1'b1;
          end
          left_ok_n = 1'b0;
          dirty_n   = 1'b0;
          fmt_n     = fmt_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      bclk_d_q  <= 1'b0;
      lr_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      left_ok_q <= 1'b0;
      dirty_q   <= 1'b0;
      fmt_q     <= FMT_LJ;
      hold_l_q  <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      bclk_d_q  <= bclk_s;
      lr_prev_q <= lr_prev_n;
      armed_q   <= armed_n;
      left_ok_q <= left_ok_n;
      dirty_q   <= dirty_n;
      fmt_q     <= fmt_n;
      hold_l_q  <= hold_l_n;
      left_o    <= left_n;
      right_o   <= right_n;
      valid_o   <= valid_n;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |=> !valid_o);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R7
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |-> !fmt_reserved($past(fmt_q)));

  // R8
  pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_o |-> !$past(pwrdn_i));

  // R9
  fmt_commit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(fmt_q) |-> ($past(bit_stb) && !$past(pwrdn_i)));

  // R5
  sext_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_o && $past(fmt_q) == FMT_RJ16) |->
      ((left_o[SAMPLE_W-1:15] == '0) || (left_o[SAMPLE_W-1:15] == '1)));

  // R11
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_stb |=> !bit_stb);

endmodule

// File: tb/pcm_rx_bench.sv
module pcm_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n, bclk, lrck, sdata, pwrdn;
  logic [2:0]  fmt;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int total = 0, fails = 0, pulses = 0, cyc = 0, rise_cyc = 0, lat = 0;
  logic [23:0] cap_l = '0, cap_r = '0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_rx u_pcm_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .pwrdn_i(pwrdn), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      pulses = pulses + 1;
      cap_l  = left_o;
      cap_r  = right_o;
      lat    = cyc - rise_cyc;
    end
  end

  // {code, left, right}
  localparam logic [50:0] VEC [10] = '{
    {3'b000, 24'h123456, 24'hFEDCBA},
    {3'b000, 24'h800000, 24'h7FFFFF},
    {3'b010, 24'h008001, 24'h007FFE},
    {3'b010, 24'hAB1234, 24'hCD8765},
    {3'b011, 24'h876543, 24'h012345},
    {3'b100, 24'h080000, 24'h07FFFF},
    {3'b101, 24'h020001, 24'h01FFFF},
    {3'b101, 24'hFC0003, 24'h00A5A5},
    {3'b001, 24'hA5A5A5, 24'h5A5A5A},
    {3'b001, 24'h000001, 24'hFFFFFF}
  };

  function automatic int width_of(logic [2:0] f);
    case (f)
      3'b010: return 16;
      3'b100: return 20;
      3'b101: return 18;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] expect_of(logic [2:0] f, logic [23:0] v);
    logic [23:0] r;
    int n;
    n = width_of(f);
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  function automatic logic enc_bit(logic [2:0] f, int k, logic [23:0] v);
    int n;
    n = width_of(f);
    if (f == 3'b001) return (k >= 1 && k <= 24) ? v[24-k] : 1'b0;
    if (f >= 3'b010 && f <= 3'b101) return (k >= 32 - n) ? v[31-k] : 1'b0;
    return (k < 24) ? v[23-k] : 1'b0;
  endfunction

  function automatic string tag_of(logic [2:0] f);
    if (f == 3'b000) return "R2";
    if (f == 3'b001) return "R3";
    return "R4 R5";
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic lr, logic d);
    @(negedge clk);
    bclk = 1'b0; lrck = lr; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    rise_cyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(logic [2:0] f, bit is_left, logic [23:0] v);
    logic lr;
    lr = (f == 3'b001) ? !is_left : is_left;
    for (int k = 0; k < 32; k++) send_bit(lr, enc_bit(f, k, v));
  endtask

  task automatic send_frame(logic [2:0] f, logic [23:0] l, logic [23:0] r);
    send_half(f, 1, l);
    send_half(f, 0, r);
  endtask

  task automatic run_vec(logic [2:0] f, logic [23:0] l, logic [23:0] r);
    fmt = f;
    send_frame(f, 24'h111111, 24'h222222);
    send_frame(f, l, r);
    send_frame(f, 24'h0, 24'h0);
    repeat (10) @(negedge clk);
    check(tag_of(f), cap_l, expect_of(f, l));
    check(tag_of(f), cap_r, expect_of(f, r));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; pwrdn = 1'b1; fmt = 3'b000;
    bclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", {23'd0, valid_o}, 24'd0);
    check("R1", left_o, 24'd0);
    check("R1", right_o, 24'd0);
    pwrdn = 1'b0;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      run_vec(VEC[i][50:48], VEC[i][47:24], VEC[i][23:0]);
      if (i == 0) check("R11", 24'(lat), 24'd3);
    end

    // R8 / R10: power-down with I2S committed
    pwrdn = 1'b1;
    p0 = pulses;
    send_frame(3'b001, 24'h333333, 24'h444444);
    check("R8", 24'(pulses - p0), 24'd0);
    fork
      send_frame(3'b001, 24'h0BAD01, 24'h0BAD02);
      begin repeat (10) @(posedge bclk); pwrdn = 1'b0; end
    join
    send_frame(3'b001, 24'hC0FFEE, 24'h13579B);
    send_frame(3'b001, 24'h0, 24'h0);
    repeat (10) @(negedge clk);
    check("R10 R6", 24'(pulses - p0), 24'd1);
    check("R8", cap_l, 24'hC0FFEE);
    check("R8", cap_r, 24'h13579B);

    // R7: reserved code
    p0 = pulses;
    fmt = 3'b110;
    send_frame(3'b110, 24'h555555, 24'h666666);
    send_frame(3'b110, 24'h777777, 24'h888888);
    send_frame(3'b110, 24'h999999, 24'hAAAAAA);
    repeat (10) @(negedge clk);
    check("R7", 24'(pulses - p0), 24'd0);
    check("R7", left_o, 24'hC0FFEE);
    check("R7", right_o, 24'h13579B);

    // R9: select change in mid-frame
    fmt = 3'b000;
    send_frame(3'b000, 24'h101010, 24'h202020);
    send_frame(3'b000, 24'h3C3C3C, 24'h4D4D4D);
    fork
      send_frame(3'b000, 24'h5E5E5E, 24'h6F6F6F);
      begin
        repeat (10) @(posedge bclk);
        p0 = pulses;
        check("R2", cap_l, 24'h3C3C3C);
        fmt = 3'b010;
      end
    join
    send_frame(3'b010, 24'h00F00D, 24'h001234);
    send_frame(3'b010, 24'h0, 24'h0);
    repeat (10) @(negedge clk);
    check("R9", 24'(pulses - p0), 24'd1);
    check("R9", cap_l, 24'hFFF00D);
    check("R9", cap_r, 24'h001234);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule